// File: doc/BRIEF.md
# Hot-Plug Slot Command Engine

This block carries out 16-bit commands that software writes to a hot-plug controller. A command word holds an operation code in its low byte and a target in its high byte. The command changes the power state and the two indicator LEDs of one slot, powers or enables every slot at once, or selects a new bus segment speed/mode. Software sees a status word with a busy bit and three error flags. The power-rail sequencing that a real slot needs is modelled as a fixed run of `EXEC_CYCLES` busy cycles.

A small state machine runs each command. `ST_IDLE` takes a write and moves to `ST_RUN` (transition *accept*). `ST_RUN` counts down the sequencing time and moves to `ST_FINISH` on its last count (transition *count_done*). `ST_FINISH` commits the decoded effect and error flags and returns to `ST_IDLE` (transition *commit*). The decode and the legality checks happen when the command is accepted, using the latch inputs sampled in that cycle. Outputs change only at *commit*.

Top module: `hpc_cmd_engine`

## Requirements
- R1: After reset, status is 0, `cmd_done` is 0, every slot state is 3 (disabled), every LED field is 3 (off) and `bus_mode` is 0.
- R2: A command written while idle is accepted. Status bit 0 (busy) is then high for exactly `EXEC_CYCLES` cycles. `cmd_done` is high for the single cycle in which busy first reads low, and the command's effects and error flags appear in that same cycle.
- R3: A write made while busy is ignored: it changes no output and no status bit. Slot, LED and mode outputs hold steady while busy.
- R4: Codes 00h–3Fh act on slot `cmd_word[15:8]`, counted from 1. Bits 1:0 give the slot state (1 power-only, 2 enabled, 3 disabled), bits 3:2 the power LED, and bits 5:4 the attention LED (1 on, 2 blink, 3 off). A field of 0 leaves that item unchanged. Slot n uses bits 2n-1:2n-2 of each output vector.
- R5: A slot operation whose state field is 1 or 2, aimed at a slot whose `latch_open` bit is set, is refused. Status bit 1 (latch open) is set and nothing changes.
- R6: The following set status bit 2 (invalid command) and change nothing: a slot operation with target 0 or a target above `NUM_SLOTS`; a bus-wide command (40h–5Fh) with a nonzero target; and codes 45h–47h, 4Ah–4Fh, 5Eh–5Fh and 60h–FFh. Only one error flag is ever set at a time.
- R7: Codes 40h–44h with target 0 set `bus_mode` to the code minus 40h.
- R8: Codes 50h–5Dh with target 0 set `bus_mode` to the code minus 50h when `PROG_LEVEL` is 2 or more. At level 1 they set status bit 3 (invalid speed/mode) and leave `bus_mode` unchanged.
- R9: Code 48h sets every slot to power-only and 49h sets every slot to enabled. If any latch is open, either code is refused with status bit 1.
- R10: Accepting a command clears all error flags. The flags then stay stable until that command completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_word | input | 16 | Command: code in bits 7:0, target in bits 15:8 |
| latch_open | input | NUM_SLOTS | Per-slot retention latch open indication |
| status | output | 4 | {invalid mode, invalid command, latch open, busy} |
| cmd_done | output | 1 | One-cycle pulse when a command completes |
| slot_state | output | 2*NUM_SLOTS | Per-slot state (1 power-only, 2 enabled, 3 disabled) |
| pwr_led | output | 2*NUM_SLOTS | Per-slot power LED (1 on, 2 blink, 3 off) |
| attn_led | output | 2*NUM_SLOTS | Per-slot attention LED (1 on, 2 blink, 3 off) |
| bus_mode | output | 4 | Current bus speed/mode code, 0 to 0Dh |

## Verification
The assertions assume that `cmd_wr` and `cmd_word` are valid whenever the strobe is high. They also assume that `latch_open` is a level, sampled only in the cycle a command is accepted. Neither the latch level nor the strobe is assumed to be held back while busy: the bench writes a second command in the middle of a busy run on purpose. The bench changes the latch inputs only while the engine is idle. It drives every input on the falling edge, so the sampled values are always settled.

// File: rtl/hpc_cmd_pkg.sv
package hpc_cmd_pkg;

    typedef enum logic [2:0] {
        OPK_NONE,
        OPK_SLOT,
        OPK_ALL_PWR,
        OPK_ALL_EN,
        OPK_BUS
    } opk_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FINISH
    } eng_state_e;

    typedef struct packed {
        opk_e       kind;
        logic [7:0] idx;
        logic [1:0] st;
        logic [1:0] pled;
        logic [1:0] aled;
        logic [3:0] mode;
        logic       e_latch;
        logic       e_cmd;
        logic       e_mode;
    } op_t;

    localparam logic [1:0] SLOT_PWRONLY  = 2'd1;
    localparam logic [1:0] SLOT_ENABLED  = 2'd2;
    localparam logic [1:0] SLOT_DISABLED = 2'd3;
    localparam logic [1:0] LED_OFF       = 2'd3;

    localparam logic [7:0] CODE_BUS_A_LAST = 8'h44;
    localparam logic [7:0] CODE_ALL_PWR    = 8'h48;
    localparam logic [7:0] CODE_ALL_EN     = 8'h49;
    localparam logic [7:0] CODE_BUS_B_LO   = 8'h50;
    localparam logic [7:0] CODE_BUS_B_HI   = 8'h5D;
    localparam logic [7:0] CODE_SLOT_END   = 8'h40;

endpackage

// File: rtl/hpc_cmd_decode.sv
module hpc_cmd_decode
    import hpc_cmd_pkg::*;
#(
    parameter int NUM_SLOTS  = 4,
    parameter int PROG_LEVEL = 2
) (
    input  logic [15:0]          cmd_word,
    input  logic [NUM_SLOTS-1:0] latch_open,
    output op_t                  op
);
    localparam logic [7:0] SLOT_LIMIT = 8'(NUM_SLOTS);
    localparam bit         HAS_SET_B  = (PROG_LEVEL >= 2);

    logic [7:0] code;
    logic [7:0] tgt;
    logic       tgt_ok;
    logic       sel_open;
    logic       powers_up;

    assign code      = cmd_word[7:0];
    assign tgt       = cmd_word[15:8];
    assign tgt_ok    = (tgt != 8'd0) && (tgt <= SLOT_LIMIT);
    assign powers_up = (code[1:0] == SLOT_PWRONLY) || (code[1:0] == SLOT_ENABLED);

    always_comb begin
        sel_open = 1'b0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (tgt == 8'(i + 1)) sel_open = latch_open[i];
        end
    end

    always_comb begin
        op      = '0;
        op.kind = OPK_NONE;
        if (code < CODE_SLOT_END) begin
            if (!tgt_ok) begin
                op.e_cmd = 1'b1;
            end else if (powers_up && sel_open) begin
                op.e_latch = 1'b1;
            end else begin
                op.kind = OPK_SLOT;
                op.idx  = tgt - 8'd1;
                op.st   = code[1:0];
                op.pled = code[3:2];
                op.aled = code[5:4];
            end
        end else if (code <= CODE_BUS_A_LAST) begin
            if (tgt != 8'd0) op.e_cmd = 1'b1;
            else begin
                op.kind = OPK_BUS;
                op.mode = code[3:0];
            end
        end else if (code == CODE_ALL_PWR || code == CODE_ALL_EN) begin
            if (tgt != 8'd0)      op.e_cmd   = 1'b1;
            else if (|latch_open) op.e_latch = 1'b1;
            else op.kind = (code == CODE_ALL_PWR) ? OPK_ALL_PWR : OPK_ALL_EN;
        end else if (code >= CODE_BUS_B_LO && code <= CODE_BUS_B_HI) begin
            if (tgt != 8'd0)     op.e_cmd  = 1'b1;
            else if (!HAS_SET_B) op.e_mode = 1'b1;
            else begin
                op.kind = OPK_BUS;
                op.mode = code[3:0];
            end
        end else begin
            op.e_cmd = 1'b1;
        end
    end

endmodule

// File: rtl/hpc_exec_fsm.sv
module hpc_exec_fsm
    import hpc_cmd_pkg::*;
#(
    parameter int EXEC_CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_wr,
    output logic accept,
    output logic finish,
    output logic busy,
    output logic done
);
    localparam int         CNT_W = (EXEC_CYCLES > 2) ? $clog2(EXEC_CYCLES) : 1;
    localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(EXEC_CYCLES - 2);

    eng_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cmd_wr) state_d = ST_RUN;
            ST_RUN:    if (cnt_q == RUN_LAST) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done    <= 1'b0;
        end else begin
            state_q <= state_d;
            done    <= (state_q == ST_FINISH);
            if (state_q == ST_RUN) cnt_q <= cnt_q + 1'b1;
            else                   cnt_q <= '0;
        end
    end

    always_comb begin
        accept = 1'b0;
        finish = 1'b0;
        busy   = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy   = 1'b0;
                accept = cmd_wr;
            end
            ST_RUN:    ;
            ST_FINISH: finish = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/hpc_slot_bank.sv
module hpc_slot_bank
    import hpc_cmd_pkg::*;
#(
    parameter int NUM_SLOTS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   apply,
    input  opk_e                   kind,
    input  logic [7:0]             idx,
    input  logic [1:0]             st,
    input  logic [1:0]             pled,
    input  logic [1:0]             aled,
    output logic [2*NUM_SLOTS-1:0] slot_state,
    output logic [2*NUM_SLOTS-1:0] pwr_led,
    output logic [2*NUM_SLOTS-1:0] attn_led
);
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic [1:0] st_q, pl_q, al_q;
        logic       hit;

        assign hit = (idx == 8'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q <= SLOT_DISABLED;
                pl_q <= LED_OFF;
                al_q <= LED_OFF;
            end else if (apply) begin
                unique case (kind)
                    OPK_SLOT: if (hit) begin
                        if (st   != 2'd0) st_q <= st;
                        if (pled != 2'd0) pl_q <= pled;
                        if (aled != 2'd0) al_q <= aled;
                    end
                    OPK_ALL_PWR: st_q <= SLOT_PWRONLY;
                    OPK_ALL_EN:  st_q <= SLOT_ENABLED;
                    default: ;
                endcase
            end
        end

        assign slot_state[2*g +: 2] = st_q;
        assign pwr_led[2*g +: 2]    = pl_q;
        assign attn_led[2*g +: 2]   = al_q;
    end

endmodule

// File: rtl/hpc_cmd_engine.sv
module hpc_cmd_engine
    import hpc_cmd_pkg::*;
#(
    parameter int NUM_SLOTS   = 4,
    parameter int EXEC_CYCLES = 6,
    parameter int PROG_LEVEL  = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_wr,
    input  logic [15:0]            cmd_word,
    input  logic [NUM_SLOTS-1:0]   latch_open,
    output logic [3:0]             status,
    output logic                   cmd_done,
    output logic [2*NUM_SLOTS-1:0] slot_state,
    output logic [2*NUM_SLOTS-1:0] pwr_led,
    output logic [2*NUM_SLOTS-1:0] attn_led,
    output logic [3:0]             bus_mode
);
    op_t  op_d, op_q;
    logic accept, finish, busy;
    logic err_latch_q, err_cmd_q, err_mode_q;
    logic [3:0] mode_q;

    hpc_cmd_decode #(.NUM_SLOTS(NUM_SLOTS), .PROG_LEVEL(PROG_LEVEL)) u_dec (
        .cmd_word   (cmd_word),
        .latch_open (latch_open),
        .op         (op_d)
    );

    hpc_exec_fsm #(.EXEC_CYCLES(EXEC_CYCLES)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_wr (cmd_wr),
        .accept (accept),
        .finish (finish),
        .busy   (busy),
        .done   (cmd_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q        <= '0;
            mode_q      <= '0;
            err_latch_q <= 1'b0;
            err_cmd_q   <= 1'b0;
            err_mode_q  <= 1'b0;
        end else if (accept) begin
            op_q        <= op_d;
            err_latch_q <= 1'b0;
            err_cmd_q   <= 1'b0;
            err_mode_q  <= 1'b0;
        end else if (finish) begin
            err_latch_q <= op_q.e_latch;
            err_cmd_q   <= op_q.e_cmd;
            err_mode_q  <= op_q.e_mode;
            if (op_q.kind == OPK_BUS) mode_q <= op_q.mode;
        end
    end

    hpc_slot_bank #(.NUM_SLOTS(NUM_SLOTS)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .apply      (finish),
        .kind       (op_q.kind),
        .idx        (op_q.idx),
        .st         (op_q.st),
        .pled       (op_q.pled),
        .aled       (op_q.aled),
        .slot_state (slot_state),
        .pwr_led    (pwr_led),
        .attn_led   (attn_led)
    );

    assign status   = {err_mode_q, err_cmd_q, err_latch_q, busy};
    assign bus_mode = mode_q;

endmodule

// File: rtl/hpc_cmd_engine_chk.sv
module hpc_cmd_engine_chk #(
    parameter int NUM_SLOTS   = 4,
    parameter int EXEC_CYCLES = 6
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [3:0]             status,
    input logic                   cmd_done,
    input logic [2*NUM_SLOTS-1:0] slot_state,
    input logic [2*NUM_SLOTS-1:0] pwr_led,
    input logic [2*NUM_SLOTS-1:0] attn_led,
    input logic [3:0]             bus_mode
);
    logic [31:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         run_len <= '0;
        else if (status[0]) run_len <= run_len + 32'd1;
        else                run_len <= '0;
    end

    assert_busy_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[0]) |-> run_len == 32'(EXEC_CYCLES));

    assert_done_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[0]) |-> cmd_done);

    assert_done_only_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> (!status[0] && $past(status[0])));

    assert_hold_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        status[0] |-> ($stable(slot_state) && $stable(pwr_led) &&
                       $stable(attn_led) && $stable(bus_mode)));

    assert_err_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(status[3:1]));

    assert_mode_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_mode <= 4'hD);

    assert_err_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[0]) |-> status[3:1] == 3'b000);

    assert_err_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && $past(status[0])) |-> $stable(status[3:1]));

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_chk
        assert_state_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
            slot_state[2*g +: 2] != 2'd0);
    end

endmodule

bind hpc_cmd_engine hpc_cmd_engine_chk #(
    .NUM_SLOTS(NUM_SLOTS),
    .EXEC_CYCLES(EXEC_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .status     (status),
    .cmd_done   (cmd_done),
    .slot_state (slot_state),
    .pwr_led    (pwr_led),
    .attn_led   (attn_led),
    .bus_mode   (bus_mode)
);

// File: tb/hpc_cmd_engine_tb_top.sv
module hpc_cmd_engine_tb_top;
    localparam int NS  = 4;
    localparam int EX  = 6;
    localparam int LVL = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_wr = 1'b0;
    logic [15:0]   cmd_word = '0;
    logic [NS-1:0] latch_open = '0;

    logic [3:0]      status, l1_status;
    logic            cmd_done, l1_done;
    logic [2*NS-1:0] slot_state, pwr_led, attn_led;
    logic [2*NS-1:0] l1_state, l1_pled, l1_aled;
    logic [3:0]      bus_mode, l1_mode;

    int n_checks = 0;
    int n_errors = 0;
    bit started  = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    hpc_cmd_engine #(.NUM_SLOTS(NS), .EXEC_CYCLES(EX), .PROG_LEVEL(LVL)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
        .latch_open(latch_open), .status(status), .cmd_done(cmd_done),
        .slot_state(slot_state), .pwr_led(pwr_led), .attn_led(attn_led),
        .bus_mode(bus_mode)
    );

    hpc_cmd_engine #(.NUM_SLOTS(NS), .EXEC_CYCLES(EX), .PROG_LEVEL(1)) dut_lvl1 (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
        .latch_open(latch_open), .status(l1_status), .cmd_done(l1_done),
        .slot_state(l1_state), .pwr_led(l1_pled), .attn_led(l1_aled),
        .bus_mode(l1_mode)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int m_cnt;
    int m_st[NS];
    int m_pl[NS];
    int m_al[NS];
    int m_mode;
    bit m_el, m_ec, m_em, m_done;
    int p_kind, p_idx, p_st, p_pl, p_al, p_mode;
    bit p_el, p_ec, p_em;

    task automatic mdecode(input logic [15:0] w, input logic [NS-1:0] lo);
        int code;
        int tgt;
        code = int'(w[7:0]);
        tgt  = int'(w[15:8]);
        p_kind = 0; p_el = 0; p_ec = 0; p_em = 0;
        if (code < 64) begin
            if (tgt < 1 || tgt > NS) p_ec = 1;
            else if ((code % 4 == 1 || code % 4 == 2) && lo[tgt-1]) p_el = 1;
            else begin
                p_kind = 1; p_idx = tgt - 1;
                p_st = code % 4; p_pl = (code / 4) % 4; p_al = (code / 16) % 4;
            end
        end else if (code <= 68) begin
            if (tgt != 0) p_ec = 1;
            else begin p_kind = 4; p_mode = code - 64; end
        end else if (code == 72 || code == 73) begin
            if (tgt != 0) p_ec = 1;
            else if (lo != 0) p_el = 1;
            else p_kind = (code == 72) ? 2 : 3;
        end else if (code >= 80 && code <= 93) begin
            if (tgt != 0) p_ec = 1;
            else if (LVL < 2) p_em = 1;
            else begin p_kind = 4; p_mode = code - 80; end
        end else p_ec = 1;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_mode = 0; m_el = 0; m_ec = 0; m_em = 0; m_done = 0;
            for (int i = 0; i < NS; i++) begin m_st[i] = 3; m_pl[i] = 3; m_al[i] = 3; end
        end else begin
            m_done = 0;
            if (m_cnt > 0) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_done = 1;
                    m_el = p_el; m_ec = p_ec; m_em = p_em;
                    if (p_kind == 1) begin
                        if (p_st != 0) m_st[p_idx] = p_st;
                        if (p_pl != 0) m_pl[p_idx] = p_pl;
                        if (p_al != 0) m_al[p_idx] = p_al;
                    end else if (p_kind == 2 || p_kind == 3) begin
                        for (int i = 0; i < NS; i++) m_st[i] = (p_kind == 2) ? 1 : 2;
                    end else if (p_kind == 4) m_mode = p_mode;
                end
            end else if (cmd_wr) begin
                m_cnt = EX; m_el = 0; m_ec = 0; m_em = 0;
                mdecode(cmd_word, latch_open);
            end
            started = 1;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && started && !finished) begin
            check("R2 busy", int'(status[0]), (m_cnt > 0) ? 1 : 0);
            check("R2 cmd_done", int'(cmd_done), int'(m_done));
            check("R5 latch error", int'(status[1]), int'(m_el));
            check("R6 invalid command", int'(status[2]), int'(m_ec));
            check("R8 invalid mode", int'(status[3]), int'(m_em));
            check("R7 bus_mode", int'(bus_mode), m_mode);
            for (int i = 0; i < NS; i++) begin
                check("R4 slot state", int'(slot_state[2*i +: 2]), m_st[i]);
                check("R4 power led", int'(pwr_led[2*i +: 2]), m_pl[i]);
                check("R4 attention led", int'(attn_led[2*i +: 2]), m_al[i]);
            end
        end
    end

    task automatic send(input logic [15:0] w);
        @(negedge clk);
        cmd_wr = 1'b1; cmd_word = w;
        @(negedge clk);
        cmd_wr = 1'b0;
        repeat (EX + 1) @(negedge clk);
    endtask

    function automatic int sst(input int n);
        return int'(slot_state[2*(n-1) +: 2]);
    endfunction

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 status", int'(status), 0);
        check("R1 done", int'(cmd_done), 0);
        check("R1 states", int'(slot_state), 8'hFF);
        check("R1 leds", int'({pwr_led, attn_led}), 16'hFFFF);
        check("R1 mode", int'(bus_mode), 0);

        // R4 slot operations
        send(16'h0101);
        check("R4 slot1 power-only", sst(1), 1);
        send(16'h023A);
        check("R4 slot2 enabled", sst(2), 2);
        check("R4 slot2 power led blink", int'(pwr_led[3:2]), 2);
        check("R4 slot2 attention off", int'(attn_led[3:2]), 3);
        send(16'h0314);
        check("R4 slot3 state unchanged", sst(3), 3);
        check("R4 slot3 leds on", int'({pwr_led[5:4], attn_led[5:4]}), 4'b0101);

        // R5 latch open refusal
        @(negedge clk); latch_open = 4'b1000;
        send(16'h0402);
        check("R5 latch status", int'(status), 4'b0010);
        check("R5 slot4 unchanged", sst(4), 3);
        send(16'h0401);
        check("R5 latch status power", int'(status), 4'b0010);
        send(16'h040C);
        check("R10 errors cleared", int'(status), 0);
        check("R4 slot4 power led off", int'(pwr_led[7:6]), 3);

        // R6 invalid targets and codes
        send(16'h0001); check("R6 target zero", int'(status), 4'b0100);
        send(16'h0501); check("R6 target high", int'(status), 4'b0100);
        send(16'h0045); check("R6 reserved 45h", int'(status), 4'b0100);
        send(16'h004A); check("R6 reserved 4Ah", int'(status), 4'b0100);
        send(16'h005E); check("R6 reserved 5Eh", int'(status), 4'b0100);
        send(16'h0070); check("R6 reserved 70h", int'(status), 4'b0100);
        send(16'h00C3); check("R6 vendor C3h", int'(status), 4'b0100);
        send(16'h0143); check("R6 bus target nonzero", int'(status), 4'b0100);
        check("R6 mode unchanged", int'(bus_mode), 0);

        // R7 / R8 bus mode
        send(16'h0043);
        check("R7 mode 3", int'(bus_mode), 3);
        check("R7 level1 mode 3", int'(l1_mode), 3);
        send(16'h005C);
        check("R8 mode 0Ch", int'(bus_mode), 4'hC);
        check("R8 level1 status", int'(l1_status), 4'b1000);
        check("R8 level1 mode kept", int'(l1_mode), 3);

        // R9 all-slot commands
        send(16'h0048);
        check("R9 latch refused", int'(status), 4'b0010);
        check("R9 slot1 kept", sst(1), 1);
        @(negedge clk); latch_open = '0;
        send(16'h0048);
        check("R9 all power-only", int'(slot_state), 8'h55);
        send(16'h0049);
        check("R9 all enabled", int'(slot_state), 8'hAA);

        // R3 write while busy is ignored
        @(negedge clk);
        cmd_wr = 1'b1; cmd_word = 16'h0044;
        @(negedge clk);
        cmd_word = 16'h0040;
        repeat (2) @(negedge clk);
        check("R3 busy during second write", int'(status[0]), 1);
        cmd_wr = 1'b0;
        repeat (EX) @(negedge clk);
        check("R3 second write ignored", int'(bus_mode), 4);
        check("R3 status clean", int'(status), 0);

        repeat (4) @(negedge clk);
        summary();
    end

endmodule